// File: doc/BRIEF.md
# Banked Register File with Condition Flags

This block holds the architectural registers of a 32-bit accumulator-style processor: sixteen named registers, one of which is the status word. Two combinational read ports and one write port serve the execution datapath. Each write carries an operation class, and the name of the target register decides which condition flags that write updates. Pointer-style registers update no flags. Data registers update negative and zero. The two full-width carry registers drive the carry flag from whether the written value is nonzero.

Six status bits bank register names onto alternate storage. One bit selects between two stack pointers. Two bits map the general registers `i` and `j` onto the two interrupt vectors and report those interrupts as masked. Three more bits map `k`, `q` and `u` onto the break vector, the non-maskable vector and a free-running tick counter. The block also steps the active stack pointer on push and pull strobes, and forces the zero register back to zero on every instruction fetch.

Register names are encoded on 4 bits: a=0, b=1, c=2, d=3, e=4, f=5 (status), s=6, i=7, j=8, k=9, q=10, u=11, w=12, x=13, y=14, z=15. Operation classes are encoded on 3 bits: load=0, logic=1, arith=2, exchange=3, add=4. Status bit positions are C=0, Z=1, V=6, N=7, S=8, I=9, J=10, K=11, Q=12, U=13.

Top module: `banked_regfile`

## Requirements
- R1: After reset every register, every alternate store and the status word read as zero, `stackAddr` is zero and `irqMask` is zero.
- R2: A value written to a register name reads back unchanged on either read port, starting in the cycle after the write edge.
- R3: While `fetchEn` is high at a clock edge, register z becomes zero, even if the same edge writes z.
- R4: With `pushEn` high alone, `stackAddr` shows the active pointer minus STACK_STEP in that cycle and the pointer takes that value. With `pullEn` high alone, `stackAddr` shows the pointer and the pointer then grows by STACK_STEP. With both high, the pointer does not change.
- R5: Status bit 8 selects which of two stack pointers the name s reaches. Changing bit 8 alters neither pointer.
- R6: Status bit 9 (or 10) maps name i (or j) onto the first (or second) interrupt vector store, and `irqMask` bit 0 (or 1) follows it. When the bit is clear, the name reaches its general store.
- R7: Status bits 11, 12 and 13 map names k, q and u onto the break vector, the non-maskable vector and the tick counter. When the bits are clear, the names reach their general stores.
- R8: The tick counter grows by one on every clock edge that does not write it. A write loads the value with no increment on that edge.
- R9: Writes to e, k, q, s or u, whatever the class, leave the status word unchanged.
- R10: Writes to a, b, i, j, w, x, y or z set N to bit 31 and Z to (value == 0) and leave all other status bits unchanged, except for arith writes to a or b.
- R11: Arith-class writes to a or b also load V from `aluOvf` and C from `aluCarry`.
- R12: Every write to c or d sets C when the value is nonzero and clears C when it is zero. All other status bits keep their values.
- R13: A write to f stores all 32 bits exactly, including the free and reserved bits. A write to C through f leaves register c unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rdAddrA | input | 4 | Read port A register name |
| rdDataA | output | 32 | Read port A data |
| rdAddrB | input | 4 | Read port B register name |
| rdDataB | output | 32 | Read port B data |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 4 | Write target name |
| wrOp | input | 3 | Operation class of the write |
| wrData | input | 32 | Write data |
| aluCarry | input | 1 | Carry out of the ALU for arith writes |
| aluOvf | input | 1 | Overflow out of the ALU for arith writes |
| pushEn | input | 1 | Push strobe |
| pullEn | input | 1 | Pull strobe |
| fetchEn | input | 1 | Instruction fetch strobe |
| stackAddr | output | 32 | Stack memory address for the current push or pull |
| statusOut | output | 32 | Current status word |
| irqMask | output | 2 | Interrupt masks from status bits 9 and 10 |

## Verification
The bound checker watches six properties on every cycle. Z reads zero after a fetch. A lone pull advances the stack address. The visible tick counter counts. Pointer writes leave the status word alone. Writes to c and d touch only the carry bit. A write to f lands verbatim. The bench scenarios cover what a cycle-local property cannot see. That includes the value held behind each banked name while its bit is set and then cleared again, reset contents, and the combined cases of write-plus-fetch and push-plus-pull. It also covers the split of flag effects between arith and non-arith writes to the data registers.

// File: rtl/banked_regfile_pkg.sv
`timescale 1ns/1ps
package banked_regfile_pkg;

  localparam int NUM_NAMES = 16;
  localparam int NUM_ALT   = 6;
  localparam int NUM_SLOTS = NUM_NAMES + NUM_ALT;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);
  localparam int BANK_W    = 6;

  // architectural register names
  localparam logic [3:0] ID_A = 4'd0;
  localparam logic [3:0] ID_B = 4'd1;
  localparam logic [3:0] ID_C = 4'd2;
  localparam logic [3:0] ID_D = 4'd3;
  localparam logic [3:0] ID_E = 4'd4;
  localparam logic [3:0] ID_F = 4'd5;
  localparam logic [3:0] ID_S = 4'd6;
  localparam logic [3:0] ID_I = 4'd7;
  localparam logic [3:0] ID_J = 4'd8;
  localparam logic [3:0] ID_K = 4'd9;
  localparam logic [3:0] ID_Q = 4'd10;
  localparam logic [3:0] ID_U = 4'd11;
  localparam logic [3:0] ID_W = 4'd12;
  localparam logic [3:0] ID_X = 4'd13;
  localparam logic [3:0] ID_Y = 4'd14;
  localparam logic [3:0] ID_Z = 4'd15;

  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_LOGIC = 3'd1,
    OP_ARITH = 3'd2,
    OP_EXCH  = 3'd3,
    OP_ADD   = 3'd4
  } wrOp_e;

  // status bit positions
  localparam int FLG_C       = 0;
  localparam int FLG_Z       = 1;
  localparam int FLG_V       = 6;
  localparam int FLG_N       = 7;
  localparam int FLG_BANK_LO = 8;

  // physical storage slots; slots below NUM_NAMES share the name index
  localparam int SLOT_STATUS = 5;
  localparam int SLOT_ZERO   = 15;
  localparam int SLOT_SP_ALT = 16;
  localparam int SLOT_IRQ1   = 17;
  localparam int SLOT_IRQ2   = 18;
  localparam int SLOT_BRK    = 19;
  localparam int SLOT_NMI    = 20;
  localparam int SLOT_TICK   = 21;

  typedef struct packed {
    logic              wrHit;
    logic [SLOT_W-1:0] wrSlot;
    logic              setNZ;
    logic              setVC;
    logic              setC;
    logic              spDec;
    logic              spInc;
    logic [SLOT_W-1:0] spSlot;
    logic              zClr;
  } rfStrobe_t;

  // bank: {U,Q,K,J,I,S}
  function automatic logic [SLOT_W-1:0] mapSlot(input logic [3:0] id,
                                               input logic [BANK_W-1:0] bank);
    logic [SLOT_W-1:0] slot;
    slot = SLOT_W'(id);
    case (id)
      ID_S: if (bank[0]) slot = SLOT_W'(SLOT_SP_ALT);
      ID_I: if (bank[1]) slot = SLOT_W'(SLOT_IRQ1);
      ID_J: if (bank[2]) slot = SLOT_W'(SLOT_IRQ2);
      ID_K: if (bank[3]) slot = SLOT_W'(SLOT_BRK);
      ID_Q: if (bank[4]) slot = SLOT_W'(SLOT_NMI);
      ID_U: if (bank[5]) slot = SLOT_W'(SLOT_TICK);
      default: ;
    endcase
    return slot;
  endfunction

endpackage

// File: rtl/banked_regfile_ctrl.sv
`timescale 1ns/1ps
module banked_regfile_ctrl
  import banked_regfile_pkg::*;
(
  input  logic              wrEn,
  input  logic [3:0]        wrAddr,
  input  logic [2:0]        wrOp,
  input  logic              pushEn,
  input  logic              pullEn,
  input  logic              fetchEn,
  input  logic [3:0]        rdAddrA,
  input  logic [3:0]        rdAddrB,
  input  logic [BANK_W-1:0] bankSel,
  output rfStrobe_t         st,
  output logic [SLOT_W-1:0] rdSlotA,
  output logic [SLOT_W-1:0] rdSlotB
);

  logic isNzTarget;
  logic isAccTarget;
  logic isCarryTarget;

  // flag policy chosen by the target name, not by the bank it lands in
  always_comb begin
    isNzTarget    = 1'b0;
    isAccTarget   = 1'b0;
    isCarryTarget = 1'b0;
    case (wrAddr)
      ID_A, ID_B: begin
        isNzTarget  = 1'b1;
        isAccTarget = 1'b1;
      end
      ID_I, ID_J, ID_W, ID_X, ID_Y, ID_Z: isNzTarget = 1'b1;
      ID_C, ID_D:                         isCarryTarget = 1'b1;
      ID_E, ID_F, ID_S, ID_K, ID_Q, ID_U: ;
      default: ;
    endcase
  end

  always_comb begin
    st.wrHit  = wrEn;
    st.wrSlot = mapSlot(wrAddr, bankSel);
    st.setVC  = wrEn && isAccTarget && (wrOp == OP_ARITH);
    st.setNZ  = wrEn && isNzTarget;
    st.setC   = wrEn && isCarryTarget;
    st.spDec  = pushEn && !pullEn;
    st.spInc  = pullEn && !pushEn;
    st.spSlot = mapSlot(ID_S, bankSel);
    st.zClr   = fetchEn;
  end

  assign rdSlotA = mapSlot(rdAddrA, bankSel);
  assign rdSlotB = mapSlot(rdAddrB, bankSel);

endmodule

// File: rtl/banked_regfile_dp.sv
`timescale 1ns/1ps
module banked_regfile_dp
  import banked_regfile_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int STACK_STEP = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  rfStrobe_t         st,
  input  logic [SLOT_W-1:0] rdSlotA,
  input  logic [SLOT_W-1:0] rdSlotB,
  input  logic [DATA_W-1:0] wrData,
  input  logic              aluCarry,
  input  logic              aluOvf,
  output logic [DATA_W-1:0] rdDataA,
  output logic [DATA_W-1:0] rdDataB,
  output logic [DATA_W-1:0] stackAddr,
  output logic [DATA_W-1:0] statusOut,
  output logic [BANK_W-1:0] bankSel
);

  localparam logic [DATA_W-1:0] STEP = DATA_W'(STACK_STEP);
  localparam logic [DATA_W-1:0] ONE  = DATA_W'(1);

  logic [DATA_W-1:0] regs     [NUM_SLOTS];
  logic [DATA_W-1:0] nextRegs [NUM_SLOTS];
  logic [DATA_W-1:0] flagsNext;

  always_comb begin
    flagsNext = regs[SLOT_STATUS];
    if (st.setNZ) begin
      flagsNext[FLG_N] = wrData[DATA_W-1];
      flagsNext[FLG_Z] = (wrData == '0);
    end
    if (st.setVC) begin
      flagsNext[FLG_V] = aluOvf;
      flagsNext[FLG_C] = aluCarry;
    end
    if (st.setC) flagsNext[FLG_C] = |wrData;
  end

  // lowest to highest priority: hold, tick, stack step, flags, write, fetch clear
  always_comb begin
    for (int n = 0; n < NUM_SLOTS; n++) nextRegs[n] = regs[n];
    nextRegs[SLOT_TICK] = regs[SLOT_TICK] + ONE;
    if (st.spDec)      nextRegs[st.spSlot] = regs[st.spSlot] - STEP;
    else if (st.spInc) nextRegs[st.spSlot] = regs[st.spSlot] + STEP;
    nextRegs[SLOT_STATUS] = flagsNext;
    if (st.wrHit) nextRegs[st.wrSlot] = wrData;
    if (st.zClr)  nextRegs[SLOT_ZERO] = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int n = 0; n < NUM_SLOTS; n++) regs[n] <= '0;
    end else begin
      for (int n = 0; n < NUM_SLOTS; n++) regs[n] <= nextRegs[n];
    end
  end

  assign rdDataA   = regs[rdSlotA];
  assign rdDataB   = regs[rdSlotB];
  assign stackAddr = st.spDec ? (regs[st.spSlot] - STEP) : regs[st.spSlot];
  assign statusOut = regs[SLOT_STATUS];
  assign bankSel   = regs[SLOT_STATUS][FLG_BANK_LO +: BANK_W];

endmodule

// File: rtl/banked_regfile.sv
`timescale 1ns/1ps
module banked_regfile
  import banked_regfile_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int STACK_STEP = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        rdAddrA,
  output logic [DATA_W-1:0] rdDataA,
  input  logic [3:0]        rdAddrB,
  output logic [DATA_W-1:0] rdDataB,
  input  logic              wrEn,
  input  logic [3:0]        wrAddr,
  input  logic [2:0]        wrOp,
  input  logic [DATA_W-1:0] wrData,
  input  logic              aluCarry,
  input  logic              aluOvf,
  input  logic              pushEn,
  input  logic              pullEn,
  input  logic              fetchEn,
  output logic [DATA_W-1:0] stackAddr,
  output logic [DATA_W-1:0] statusOut,
  output logic [1:0]        irqMask
);

  rfStrobe_t         st;
  logic [SLOT_W-1:0] rdSlotA;
  logic [SLOT_W-1:0] rdSlotB;
  logic [BANK_W-1:0] bankSel;

  banked_regfile_ctrl u_ctrl (
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrOp    (wrOp),
    .pushEn  (pushEn),
    .pullEn  (pullEn),
    .fetchEn (fetchEn),
    .rdAddrA (rdAddrA),
    .rdAddrB (rdAddrB),
    .bankSel (bankSel),
    .st      (st),
    .rdSlotA (rdSlotA),
    .rdSlotB (rdSlotB)
  );

  banked_regfile_dp #(
    .DATA_W     (DATA_W),
    .STACK_STEP (STACK_STEP)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .rdSlotA   (rdSlotA),
    .rdSlotB   (rdSlotB),
    .wrData    (wrData),
    .aluCarry  (aluCarry),
    .aluOvf    (aluOvf),
    .rdDataA   (rdDataA),
    .rdDataB   (rdDataB),
    .stackAddr (stackAddr),
    .statusOut (statusOut),
    .bankSel   (bankSel)
  );

  assign irqMask = bankSel[2:1];

endmodule

// File: rtl/banked_regfile_chk.sv
`timescale 1ns/1ps
module banked_regfile_chk
  import banked_regfile_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int STACK_STEP = 1
) (
  input logic              clk,
  input logic              rstN,
  input logic [3:0]        rdAddrA,
  input logic [DATA_W-1:0] rdDataA,
  input logic              wrEn,
  input logic [3:0]        wrAddr,
  input logic [DATA_W-1:0] wrData,
  input logic              pushEn,
  input logic              pullEn,
  input logic              fetchEn,
  input logic [DATA_W-1:0] stackAddr,
  input logic [DATA_W-1:0] statusOut
);

  localparam logic [DATA_W-1:0] STEP = DATA_W'(STACK_STEP);

  logic pastValid;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pastValid <= 1'b0;
    else       pastValid <= 1'b1;
  end

  logic ptrWrite, carryWrite, statusWrite, stackWrite, tickWrite, tickVisible;
  assign ptrWrite    = wrEn && (wrAddr == ID_E || wrAddr == ID_K || wrAddr == ID_Q ||
                                wrAddr == ID_S || wrAddr == ID_U);
  assign carryWrite  = wrEn && (wrAddr == ID_C || wrAddr == ID_D);
  assign statusWrite = wrEn && (wrAddr == ID_F);
  assign stackWrite  = wrEn && (wrAddr == ID_S);
  assign tickWrite   = wrEn && (wrAddr == ID_U);
  assign tickVisible = statusOut[13] && (rdAddrA == ID_U);

  // R3
  z_after_fetch_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(fetchEn) && rdAddrA == ID_Z) |-> (rdDataA == '0));

  // R4
  pull_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(pullEn && !pushEn && !stackWrite && !statusWrite) && !pushEn)
    |-> (stackAddr == $past(stackAddr) + STEP));

  // R8
  tick_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(tickVisible && !tickWrite && !statusWrite) && tickVisible)
    |-> (rdDataA == $past(rdDataA) + DATA_W'(1)));

  // R9
  ptr_no_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(ptrWrite)) |-> (statusOut == $past(statusOut)));

  // R12
  carry_reg_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(carryWrite))
    |-> (statusOut[0] == ($past(wrData) != '0) &&
         statusOut[DATA_W-1:1] == $past(statusOut[DATA_W-1:1])));

  // R13
  status_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(statusWrite)) |-> (statusOut == $past(wrData)));

endmodule

bind banked_regfile banked_regfile_chk #(
  .DATA_W     (DATA_W),
  .STACK_STEP (STACK_STEP)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .rdAddrA   (rdAddrA),
  .rdDataA   (rdDataA),
  .wrEn      (wrEn),
  .wrAddr    (wrAddr),
  .wrData    (wrData),
  .pushEn    (pushEn),
  .pullEn    (pullEn),
  .fetchEn   (fetchEn),
  .stackAddr (stackAddr),
  .statusOut (statusOut)
);

// File: tb/banked_regfile_bench.sv
`timescale 1ns/1ps
module banked_regfile_bench;
  import banked_regfile_pkg::*;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  rdAddrA = '0, rdAddrB = '0, wrAddr = '0;
  logic [31:0] rdDataA, rdDataB, wrData = '0, stackAddr, statusOut;
  logic [2:0]  wrOp = '0;
  logic        wrEn = 1'b0, aluCarry = 1'b0, aluOvf = 1'b0;
  logic        pushEn = 1'b0, pullEn = 1'b0, fetchEn = 1'b0;
  logic [1:0]  irqMask;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  banked_regfile u_banked_regfile (
    .clk(clk), .rstN(rstN),
    .rdAddrA(rdAddrA), .rdDataA(rdDataA), .rdAddrB(rdAddrB), .rdDataB(rdDataB),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrOp(wrOp), .wrData(wrData),
    .aluCarry(aluCarry), .aluOvf(aluOvf),
    .pushEn(pushEn), .pullEn(pullEn), .fetchEn(fetchEn),
    .stackAddr(stackAddr), .statusOut(statusOut), .irqMask(irqMask)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wrFull(input logic [3:0] id, input logic [31:0] d, input logic [2:0] op,
                        input logic c, input logic v);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = id; wrData = d; wrOp = op; aluCarry = c; aluOvf = v;
    @(negedge clk);
    wrEn = 1'b0; aluCarry = 1'b0; aluOvf = 1'b0;
  endtask

  task automatic wr(input logic [3:0] id, input logic [31:0] d);
    wrFull(id, d, OP_LOAD, 1'b0, 1'b0);
  endtask

  task automatic expectReg(input string tag, input logic [3:0] id, input logic [31:0] exp);
    @(negedge clk);
    rdAddrA = id;
    #1;
    chk(tag, rdDataA, exp);
  endtask

  task automatic t_reset();
    expectReg("R1 a after reset", ID_A, 32'h0);
    expectReg("R1 f after reset", ID_F, 32'h0);
    expectReg("R1 s after reset", ID_S, 32'h0);
    expectReg("R1 z after reset", ID_Z, 32'h0);
    chk("R1 stackAddr after reset", stackAddr, 32'h0);
    chk("R1 irqMask after reset", {30'h0, irqMask}, 32'h0);
  endtask

  task automatic t_status();
    wr(ID_F, 32'hABCC_003C);
    expectReg("R13 status readback incl reserved", ID_F, 32'hABCC_003C);
    chk("R13 statusOut port", statusOut, 32'hABCC_003C);
    wr(ID_F, 32'h0000_0030);
    chk("R13 free bits 4,5", statusOut, 32'h30);
  endtask

  task automatic t_rw();
    wrFull(ID_A, 32'h1234_5678, OP_LOAD, 1'b0, 1'b0);
    expectReg("R2 a readback", ID_A, 32'h1234_5678);
    chk("R10 load a positive flags", statusOut, 32'h30);
    wrFull(ID_X, 32'h8000_0000, OP_EXCH, 1'b0, 1'b0);
    chk("R10 exchange x sets N", statusOut, 32'hB0);
    @(negedge clk);
    rdAddrB = ID_X;
    #1;
    chk("R2 x via port B", rdDataB, 32'h8000_0000);
    wrFull(ID_Y, 32'h0, OP_ADD, 1'b0, 1'b0);
    chk("R10 add y zero sets Z", statusOut, 32'h32);
    wrFull(ID_W, 32'h7, OP_LOGIC, 1'b0, 1'b0);
    chk("R10 logic w clears N,Z", statusOut, 32'h30);
    expectReg("R2 w readback", ID_W, 32'h7);
  endtask

  task automatic t_carry();
    wr(ID_Y, 32'h0);
    chk("R10 y zero", statusOut, 32'h32);
    wr(ID_C, 32'h5);
    chk("R12 c nonzero sets C keeps Z", statusOut, 32'h33);
    expectReg("R2 c readback", ID_C, 32'h5);
    wr(ID_C, 32'h0);
    chk("R12 c zero clears C keeps Z", statusOut, 32'h32);
    wr(ID_D, 32'h8000_0000);
    chk("R12 d nonzero sets C, N unchanged", statusOut, 32'h33);
    wr(ID_F, 32'h31);
    expectReg("R13 C written directly leaves c", ID_C, 32'h0);
    expectReg("R12 d kept", ID_D, 32'h8000_0000);
  endtask

  task automatic t_arith();
    wr(ID_F, 32'h0);
    wrFull(ID_A, 32'h0, OP_ARITH, 1'b1, 1'b1);
    chk("R11 arith a: Z,V,C", statusOut, 32'h43);
    wrFull(ID_A, 32'h1, OP_LOGIC, 1'b0, 1'b0);
    chk("R10 logic a keeps V,C", statusOut, 32'h41);
    wrFull(ID_W, 32'h5, OP_ARITH, 1'b0, 1'b0);
    chk("R10 arith w keeps V,C", statusOut, 32'h41);
    wrFull(ID_B, 32'h8000_0001, OP_ARITH, 1'b0, 1'b0);
    chk("R11 arith b: N, V,C from ALU", statusOut, 32'h80);
  endtask

  task automatic t_ptr();
    wr(ID_F, 32'h83);
    wrFull(ID_E, 32'h0, OP_LOAD, 1'b1, 1'b1);
    chk("R9 e write no flags", statusOut, 32'h83);
    wrFull(ID_K, 32'h5, OP_ADD, 1'b0, 1'b0);
    wrFull(ID_Q, 32'h0, OP_EXCH, 1'b0, 1'b0);
    wrFull(ID_S, 32'h7, OP_ARITH, 1'b0, 1'b1);
    wrFull(ID_U, 32'h9, OP_LOGIC, 1'b0, 1'b0);
    chk("R9 k,q,s,u writes no flags", statusOut, 32'h83);
    expectReg("R2 k readback", ID_K, 32'h5);
    expectReg("R2 u readback", ID_U, 32'h9);
  endtask

  task automatic t_zero();
    wr(ID_Z, 32'h55);
    expectReg("R2 z holds written value", ID_Z, 32'h55);
    @(negedge clk); fetchEn = 1'b1;
    @(negedge clk); fetchEn = 1'b0;
    expectReg("R3 z cleared by fetch", ID_Z, 32'h0);
    @(negedge clk);
    fetchEn = 1'b1; wrEn = 1'b1; wrAddr = ID_Z; wrData = 32'h66; wrOp = OP_LOAD;
    @(negedge clk);
    fetchEn = 1'b0; wrEn = 1'b0;
    expectReg("R3 fetch beats z write", ID_Z, 32'h0);
  endtask

  task automatic t_stack();
    wr(ID_F, 32'h0);
    wr(ID_S, 32'd100);
    @(negedge clk); pushEn = 1'b1; #1;
    chk("R4 push address predecremented", stackAddr, 32'd99);
    @(negedge clk); pushEn = 1'b0;
    expectReg("R4 s after push", ID_S, 32'd99);
    @(negedge clk); pullEn = 1'b1; #1;
    chk("R4 pull address is pointer", stackAddr, 32'd99);
    @(negedge clk); pullEn = 1'b0;
    expectReg("R4 s after pull", ID_S, 32'd100);
    @(negedge clk); pushEn = 1'b1; pullEn = 1'b1;
    @(negedge clk); pushEn = 1'b0; pullEn = 1'b0;
    expectReg("R4 push+pull no change", ID_S, 32'd100);
  endtask

  task automatic t_spbank();
    wr(ID_F, 32'h100);
    expectReg("R5 alternate pointer reset", ID_S, 32'h0);
    wr(ID_S, 32'd200);
    @(negedge clk); pushEn = 1'b1; #1;
    chk("R5 push uses alternate pointer", stackAddr, 32'd199);
    @(negedge clk); pushEn = 1'b0;
    wr(ID_F, 32'h0);
    expectReg("R5 primary pointer kept", ID_S, 32'd100);
    wr(ID_F, 32'h100);
    expectReg("R5 alternate pointer kept", ID_S, 32'd199);
  endtask

  task automatic t_irqbank();
    wr(ID_F, 32'h0);
    wr(ID_I, 32'h11);
    wr(ID_J, 32'h22);
    wr(ID_F, 32'h200);
    chk("R6 irqMask I only", {30'h0, irqMask}, 32'h1);
    expectReg("R6 i reaches vector 1", ID_I, 32'h0);
    expectReg("R6 j still general", ID_J, 32'h22);
    wr(ID_I, 32'hA0);
    wr(ID_F, 32'h600);
    chk("R6 irqMask both", {30'h0, irqMask}, 32'h3);
    expectReg("R6 j reaches vector 2", ID_J, 32'h0);
    wr(ID_J, 32'hB0);
    wr(ID_F, 32'h0);
    chk("R6 irqMask clear", {30'h0, irqMask}, 32'h0);
    expectReg("R6 general i kept", ID_I, 32'h11);
    expectReg("R6 general j kept", ID_J, 32'h22);
    wr(ID_F, 32'h600);
    expectReg("R6 vector 1 kept", ID_I, 32'hA0);
    expectReg("R6 vector 2 kept", ID_J, 32'hB0);
  endtask

  task automatic t_kqu();
    wr(ID_F, 32'h0);
    wr(ID_K, 32'h5);
    wr(ID_Q, 32'h6);
    wr(ID_U, 32'h9);
    wr(ID_F, 32'h1800);
    expectReg("R7 k reaches break vector", ID_K, 32'h0);
    expectReg("R7 q reaches nmi vector", ID_Q, 32'h0);
    wr(ID_K, 32'hB1);
    wr(ID_Q, 32'hC2);
    wr(ID_F, 32'h0);
    expectReg("R7 general k kept", ID_K, 32'h5);
    expectReg("R7 general q kept", ID_Q, 32'h6);
    expectReg("R7 general u kept", ID_U, 32'h9);
    wr(ID_F, 32'h1800);
    expectReg("R7 break vector kept", ID_K, 32'hB1);
    expectReg("R7 nmi vector kept", ID_Q, 32'hC2);
  endtask

  task automatic t_tick();
    logic [31:0] first;
    wr(ID_F, 32'h2000);
    @(negedge clk); rdAddrA = ID_U; #1; first = rdDataA;
    chk("R8 tick running since reset", {31'h0, first != 32'h0}, 32'h1);
    @(negedge clk); #1;
    chk("R8 tick +1 per clock", rdDataA, first + 32'd1);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = ID_U; wrData = 32'd1000; wrOp = OP_LOAD;
    @(negedge clk);
    wrEn = 1'b0; rdAddrA = ID_U; #1;
    chk("R8 write loads tick without increment", rdDataA, 32'd1000);
    @(negedge clk); #1;
    chk("R8 tick resumes after write", rdDataA, 32'd1001);
    wr(ID_F, 32'h0);
    expectReg("R7 u general when U clear", ID_U, 32'h9);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_status();
    t_rw();
    t_carry();
    t_arith();
    t_ptr();
    t_zero();
    t_stack();
    t_spbank();
    t_irqbank();
    t_kqu();
    t_tick();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule